// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block merges the interrupt conditions of a UART into one byte that the host reads to find out why it was interrupted. Each cycle it takes five raw conditions and a four-bit enable mask: line-status error, receive data available, character timeout, transmit holding empty and modem-status change. It forms the encoded identity of the most urgent enabled condition and drives a request line that goes high when any enabled condition is pending. Bits 7:6 of the byte tell whether the FIFOs are on.

When the host reads the identification register, the byte it sees is captured at the start of the access and held until the access ends. A condition that arrives during the read therefore cannot change the value in the middle of the read. The request line keeps following the live conditions at all times. The sources clear their own conditions. This block only reports them.

Top module: `uart_int_ident`

## Requirements
- R1: Bit 0 of `iid_o` is active low. It is 0 when any enabled condition is pending and 1 otherwise, so with nothing pending and FIFO mode off the byte reads 0x01.
- R2: Bits 3:1 identify the winning source. From highest to lowest priority the codes are: line-status error 011, receive data available 010, transmit holding empty 001, modem-status change 000. A lower source is reported only when no higher enabled source is pending.
- R3: In FIFO mode an enabled character timeout reports code 110 in bits 3:1. It shares the receive level and wins over receive data available. With FIFO mode off the timeout condition is ignored and bit 3 is always 0.
- R4: Bits 5:4 of `iid_o` always read 0.
- R5: Bits 7:6 of `iid_o` both read 1 while `fifo_mode_i` is 1, and both read 0 while it is 0.
- R6: The enable mask works per source. `int_en_i[0]` enables receive data and timeout, bit 1 enables transmit holding empty, bit 2 enables line-status error and bit 3 enables modem-status change. A disabled condition is neither reported nor requested.
- R7: `irq_o` is high exactly when at least one enabled condition is pending, where timeout counts only in FIFO mode. It is never held by a read.
- R8: A read access is `rd_i` high together with `addr_i` equal to 2. The byte shown in the first cycle of the access is held on `iid_o` for the whole access, even when conditions change.
- R9: With `rd_i` high and `addr_i` not equal to 2, nothing is held and `iid_o` follows the live conditions.
- R10: In the first cycle in which the access is no longer active, `iid_o` shows the live value again.
- R11: After reset with all conditions low, `iid_o` is 0x01 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_err_i | input | 1 | Line-status error condition |
| rx_data_i | input | 1 | Receive data available condition |
| rx_tmo_i | input | 1 | Character timeout condition |
| tx_empty_i | input | 1 | Transmit holding empty condition |
| modem_chg_i | input | 1 | Modem-status change condition |
| int_en_i | input | 4 | Per-source enable mask |
| fifo_mode_i | input | 1 | FIFOs enabled |
| rd_i | input | 1 | Host read strobe |
| addr_i | input | 3 | Host register offset |
| iid_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- the reserved bits stay zero,
- bits 7:6 follow the FIFO flag,
- bit 3 stays clear outside FIFO mode,
- at most one source is granted,
- outside an access, bit 0 is the complement of the request line,
- the byte does not move while an access stays open.

Only the bench scenarios can show the meaning of the values themselves. These are the exact code for each source, the order in which sources beat one another, the effect of the enable mask and the timeout override. They also cover the cycle in which the byte is captured and released, and the case where a read at another offset has no effect.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

    localparam int NUM_EN   = 4;
    localparam int NUM_COND = 5;

    typedef enum logic [2:0] {
        ID_LINE_ERR = 3'b011,
        ID_RX_DATA  = 3'b010,
        ID_RX_TMO   = 3'b110,
        ID_TX_EMPTY = 3'b001,
        ID_MODEM    = 3'b000
    } src_id_e;

    // Condition vector, index order fixes priority (0 = most urgent).
    localparam int C_LINE = 0;
    localparam int C_TMO  = 1;
    localparam int C_RXD  = 2;
    localparam int C_TXE  = 3;
    localparam int C_MDM  = 4;

    typedef struct packed {
        logic    pend;
        src_id_e id;
    } win_t;

    // Which enable bit gates each condition.
    function automatic int en_index(input int cond);
        case (cond)
            C_LINE:  return 2;
            C_TMO:   return 0;
            C_RXD:   return 0;
            C_TXE:   return 1;
            default: return 3;
        endcase
    endfunction

    function automatic src_id_e cond_id(input int cond);
        case (cond)
            C_LINE:  return ID_LINE_ERR;
            C_TMO:   return ID_RX_TMO;
            C_RXD:   return ID_RX_DATA;
            C_TXE:   return ID_TX_EMPTY;
            default: return ID_MODEM;
        endcase
    endfunction

    function automatic logic [7:0] pack_id(input win_t w, input logic fifo);
        return {{2{fifo}}, 2'b00, w.id, ~w.pend};
    endfunction

endpackage

// File: rtl/iid_req_mask.sv
module iid_req_mask
    import uart_iid_pkg::*;
(
    input  logic [NUM_COND-1:0] raw_i,
    input  logic [NUM_EN-1:0]   en_i,
    input  logic                fifo_i,
    output logic [NUM_COND-1:0] req_o,
    output logic                any_o
);
    logic [NUM_COND-1:0] allow;

    for (genvar g = 0; g < NUM_COND; g++) begin : g_mask
        if (g == C_TMO) begin : g_tmo
            assign allow[g] = en_i[en_index(g)] & fifo_i;
        end else begin : g_std
            assign allow[g] = en_i[en_index(g)];
        end
        assign req_o[g] = raw_i[g] & allow[g];
    end

    assign any_o = |req_o;
endmodule

// File: rtl/iid_prio_enc.sv
module iid_prio_enc
    import uart_iid_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_COND-1:0] req_i,
    output logic [NUM_COND-1:0] grant_o,
    output win_t                win_o
);
    always_comb begin
        grant_o = '0;
        win_o   = '{pend: 1'b0, id: ID_MODEM};
        for (int i = NUM_COND - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                win_o      = '{pend: 1'b1, id: cond_id(i)};
            end
        end
    end

    // R2: only one source may win
    a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));
    // R1: pending flag tracks presence of a winner
    a_r1_pend_matches: assert property (@(posedge clk) disable iff (rst)
        win_o.pend == ($countones(grant_o) == 1));
endmodule

// File: rtl/iid_hold.sv
module iid_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         act_i,
    input  logic [W-1:0] live_i,
    output logic [W-1:0] out_o
);
    logic         held_q;
    logic [W-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            snap_q <= '0;
        end else begin
            held_q <= act_i;
            if (act_i && !held_q) snap_q <= live_i;
        end
    end

    assign out_o = (act_i && held_q) ? snap_q : live_i;

    // R8: value stays put while the access remains open
    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        act_i |=> (!act_i || $stable(out_o)));
    // R10: outside an access the live value is shown
    a_r10_release: assert property (@(posedge clk) disable iff (rst)
        !act_i |-> out_o == live_i);
endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
    import uart_iid_pkg::*;
#(
    parameter int          ADDR_W     = 3,
    parameter logic [ADDR_W-1:0] IID_OFFSET = 3'd2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_err_i,
    input  logic              rx_data_i,
    input  logic              rx_tmo_i,
    input  logic              tx_empty_i,
    input  logic              modem_chg_i,
    input  logic [NUM_EN-1:0] int_en_i,
    input  logic              fifo_mode_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        iid_o,
    output logic              irq_o
);
    logic [NUM_COND-1:0] raw, req, grant;
    win_t                win;
    logic [7:0]          live;
    logic                rd_act;

    always_comb begin
        raw        = '0;
        raw[C_LINE] = line_err_i;
        raw[C_TMO]  = rx_tmo_i;
        raw[C_RXD]  = rx_data_i;
        raw[C_TXE]  = tx_empty_i;
        raw[C_MDM]  = modem_chg_i;
    end

    iid_req_mask u_mask (
        .raw_i (raw),
        .en_i  (int_en_i),
        .fifo_i(fifo_mode_i),
        .req_o (req),
        .any_o (irq_o)
    );

    iid_prio_enc u_enc (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req),
        .grant_o(grant),
        .win_o  (win)
    );

    assign live   = pack_id(win, fifo_mode_i);
    assign rd_act = rd_i && (addr_i == IID_OFFSET);

    iid_hold #(.W(8)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .act_i (rd_act),
        .live_i(live),
        .out_o (iid_o)
    );

    // R4: reserved bits
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        iid_o[5:4] == 2'b00);
    // R5: FIFO flag bits
    a_r5_fifo_bits: assert property (@(posedge clk) disable iff (rst)
        !rd_act |-> iid_o[7:6] == {2{fifo_mode_i}});
    // R3: timeout bit absent outside FIFO mode
    a_r3_no_tmo_bit: assert property (@(posedge clk) disable iff (rst)
        (!rd_act && !fifo_mode_i) |-> !iid_o[3]);
    // R1 / R7: bit 0 complements the request line when live
    a_r7_irq_vs_bit0: assert property (@(posedge clk) disable iff (rst)
        !rd_act |-> iid_o[0] == !irq_o);
endmodule

// File: tb/uart_int_ident_bench.sv
`timescale 1ns/1ps
module uart_int_ident_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       line_err, rx_data, rx_tmo, tx_empty, modem_chg;
    logic [3:0] int_en;
    logic       fifo_mode, rd;
    logic [2:0] addr;
    logic [7:0] iid;
    logic       irq;
    int         checks = 0;
    int         fails  = 0;

    always #2.5 clk = ~clk;

    uart_int_ident u_uart_int_ident (
        .clk(clk), .rst(rst), .line_err_i(line_err), .rx_data_i(rx_data),
        .rx_tmo_i(rx_tmo), .tx_empty_i(tx_empty), .modem_chg_i(modem_chg),
        .int_en_i(int_en), .fifo_mode_i(fifo_mode), .rd_i(rd),
        .addr_i(addr), .iid_o(iid), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // drive on falling edge, sample 1 ns later
    task automatic drive(input logic [4:0] s); // {line,tmo,rxd,txe,mdm}
        @(negedge clk);
        {line_err, rx_tmo, rx_data, tx_empty, modem_chg} = s;
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1; rd = 0; addr = 0; int_en = 4'hF; fifo_mode = 0;
        {line_err, rx_tmo, rx_data, tx_empty, modem_chg} = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        chk("R11 idle byte", iid, 8'h01);
        chk("R11 irq low", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_priority();
        drive(5'b00001); chk("R2 modem", iid, 8'h00);
        chk("R7 irq high", {7'd0, irq}, 8'h01);
        drive(5'b00011); chk("R2 thr over modem", iid, 8'h02);
        drive(5'b00111); chk("R2 rxd over thr", iid, 8'h04);
        drive(5'b10111); chk("R2 line over all", iid, 8'h06);
        drive(5'b00000); chk("R1 none pending", iid, 8'h01);
    endtask

    task automatic t_timeout();
        drive(5'b01000); chk("R3 tmo ignored non-FIFO", iid, 8'h01);
        chk("R7 tmo no irq non-FIFO", {7'd0, irq}, 8'h00);
        drive(5'b01100); chk("R3 rxd when non-FIFO", iid, 8'h04);
        fifo_mode = 1'b1;
        drive(5'b01100); chk("R3 tmo over rxd", iid, 8'hCC);
        drive(5'b00100); chk("R5 fifo rxd", iid, 8'hC4);
        drive(5'b11100); chk("R3 line over tmo", iid, 8'hC6);
        drive(5'b00000); chk("R5 fifo idle", iid, 8'hC1);
        chk("R4 reserved", {6'd0, iid[5:4]}, 8'h00);
        fifo_mode = 1'b0;
        drive(5'b00000); chk("R5 bits clear", iid, 8'h01);
    endtask

    task automatic t_mask();
        int_en = 4'b1011; // line error disabled
        drive(5'b10010); chk("R6 line masked", iid, 8'h02);
        int_en = 4'b1001; // thr also disabled
        drive(5'b10010); chk("R6 all masked", iid, 8'h01);
        chk("R6 no irq", {7'd0, irq}, 8'h00);
        int_en = 4'b0000;
        drive(5'b00001); chk("R6 modem masked", iid, 8'h01);
        int_en = 4'hF;
        drive(5'b00000);
    endtask

    task automatic t_freeze();
        drive(5'b00010);
        rd = 1'b0;
        @(negedge clk); rd = 1'b1; addr = 3'd2; #1;
        chk("R8 first cycle", iid, 8'h02);
        drive(5'b10010);
        chk("R8 held", iid, 8'h02);
        chk("R7 irq live during read", {7'd0, irq}, 8'h01);
        drive(5'b10011);
        chk("R8 still held", iid, 8'h02);
        @(negedge clk); rd = 1'b0; #1;
        chk("R10 released", iid, 8'h06);
        drive(5'b00000);
    endtask

    task automatic t_addr();
        @(negedge clk); rd = 1'b1; addr = 3'd3; #1;
        drive(5'b00001); chk("R9 other offset live", iid, 8'h00);
        drive(5'b00100); chk("R9 other offset follows", iid, 8'h04);
        @(negedge clk); rd = 1'b0; addr = 3'd0;
        drive(5'b00000);
    endtask

    initial begin
        t_reset();
        t_priority();
        t_timeout();
        t_mask();
        t_freeze();
        t_addr();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule